// File: doc/BRIEF.md
# SMBus Host Transaction Sequencer

This block turns one requested SMBus transaction into the ordered list of bus primitives that carries it out: start, repeated start, address bytes, the command byte, counts, payload bytes, an optional packet-error-check byte, and the final stop. Each primitive goes to a separate bit-level engine through a small handshake. The engine reports back the ACK it saw on a written byte, or the byte it read. The sequencer decides on its own whether to ACK or NACK each byte it reads.

A requester presents the transaction kind, the 7-bit target address, the command byte, a block length and a PEC enable with a one-cycle `req_valid`. Payload bytes for writes are taken from `tx_byte`, and `tx_pop` pulses as each one is consumed. Bytes read from the device come out on `rx_data` with an `rx_valid` pulse. A `done` pulse closes every request, and three error flags are valid alongside it.

Top module: `smbus_seq`

## Requirements
- R1: Primitive codes on `prim_op` are 0 start, 1 stop, 2 write byte, 3 read byte. Every start is followed by an address byte, with the address in bits 7:1 and the direction in bit 0 (1 read, 0 write). A primitive stays presented until the cycle in which `prim_done` is high.
- R2: Kind 0 (quick) issues start, the address byte with `req_rw` as its direction bit, and stop. It has no command, no data and no PEC.
- R3: Register reads (kind 4 read byte, 6 read word, 7 process call, 9 block read, 10 block process call) send the address with write, then the command byte and any outgoing data, then a repeated start and the address with read.
- R4: 16-bit values travel low byte first. Kind 5 writes two bytes, kind 6 reads two, and kind 7 writes two and then reads two.
- R5: Every byte read is ACKed (`prim_ack_out`=1) except the final byte, which is NACKed. Each data byte read is delivered on `rx_data` in bus order.
- R6: Kind 9 reads a count byte first and then exactly that many data bytes, with 1 to 32 allowed.
- R7: Kind 8 sends the command, then `req_len` as a count byte, then `req_len` payload bytes (1 to 32). `tx_pop` pulses once per payload byte.
- R8: Kind 10 sends a count and 1 to 31 payload bytes, then after a repeated start reads a count and 1 to 31 data bytes.
- R9: With `req_pec` set (not kind 0), a CRC-8 byte (polynomial x^8+x^2+x+1, initial value 0, over every bus byte including addresses and counts) goes just before stop. On writes it is sent. On reads the last data byte is ACKed and the PEC byte is read and NACKed.
- R10: A NACK on any written byte ends the transaction at once with stop, and `err_nack` is set.
- R11: A received count of 0 or above the limit for the kind sets `err_count` and is followed directly by stop. A request with kind above 10 or an out-of-range block length finishes with `err_count` and makes no bus activity.
- R12: A received PEC byte that differs from the computed CRC sets `err_pec`.
- R13: `req_valid` is ignored while a transaction is in progress.
- R14: Kind 1 (send byte) writes one payload byte after the address. Kind 2 (receive byte) reads one byte with the read direction. Kind 3 (write byte) writes the command and then one payload byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, accepted when idle |
| req_kind | input | 4 | Transaction kind code |
| req_addr | input | 7 | Target address |
| req_rw | input | 1 | Direction bit for the quick kind |
| req_cmd | input | 8 | Command byte |
| req_len | input | CW | Outgoing block length |
| req_pec | input | 1 | Append or check a PEC byte |
| tx_byte | input | 8 | Next outgoing payload byte |
| tx_pop | output | 1 | Payload byte consumed |
| rx_valid | output | 1 | Received data byte strobe |
| rx_data | output | 8 | Received data byte |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Transaction finished pulse |
| err_nack | output | 1 | Written byte was NACKed |
| err_count | output | 1 | Bad count received or bad request |
| err_pec | output | 1 | PEC mismatch on read |
| prim_valid | output | 1 | Primitive presented |
| prim_op | output | 2 | Primitive code |
| prim_wdata | output | 8 | Byte for a write primitive |
| prim_ack_out | output | 1 | ACK (1) or NACK (0) for a read primitive |
| prim_done | input | 1 | Primitive complete |
| prim_rx_ack | input | 1 | ACK seen on a written byte |
| prim_rdata | input | 8 | Byte returned by a read primitive |

## Verification
The hardest situations to reach are the failure paths in the middle of a transaction: a NACK on one particular written byte, a malformed count returned by the device, and a corrupted PEC byte. A clean run never produces them. The bench plays the device itself and builds the full expected primitive trace for each request. It then replays that trace, forcing a NACK at each write position in turn, substituting out-of-range counts at the count position, and inverting the PEC byte. It also sweeps every kind, both PEC settings and every legal block length.

// File: rtl/smbus_seq.sv
module smbus_seq #(
  parameter int MAX_BLOCK = 32,
  localparam int CW = $clog2(MAX_BLOCK + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [3:0]    req_kind,
  input  logic [6:0]    req_addr,
  input  logic          req_rw,
  input  logic [7:0]    req_cmd,
  input  logic [CW-1:0] req_len,
  input  logic          req_pec,
  input  logic [7:0]    tx_byte,
  output logic          tx_pop,
  output logic          rx_valid,
  output logic [7:0]    rx_data,
  output logic          busy,
  output logic          done,
  output logic          err_nack,
  output logic          err_count,
  output logic          err_pec,
  output logic          prim_valid,
  output logic [1:0]    prim_op,
  output logic [7:0]    prim_wdata,
  output logic          prim_ack_out,
  input  logic          prim_done,
  input  logic          prim_rx_ack,
  input  logic [7:0]    prim_rdata
);

  localparam logic [3:0] K_QUICK = 4'd0, K_SEND = 4'd1, K_RECV = 4'd2, K_WBYTE = 4'd3,
                         K_RBYTE = 4'd4, K_WWORD = 4'd5, K_RWORD = 4'd6, K_PROC = 4'd7,
                         K_BWRITE = 4'd8, K_BREAD = 4'd9, K_BPROC = 4'd10;
  localparam logic [1:0] OP_START = 2'd0, OP_STOP = 2'd1, OP_WR = 2'd2, OP_RD = 2'd3;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_ADDR, S_CMD, S_WCNT, S_WDATA, S_RSTART,
    S_ADDR_R, S_RCNT, S_RDATA, S_WPEC, S_RPEC, S_STOP
  } st_t;

  st_t           st;
  logic [3:0]    kind_q;
  logic [6:0]    addr_q;
  logic          dir_q, pec_q;
  logic [7:0]    cmd_q, crc;
  logic [CW-1:0] len_q, rem;

  function automatic logic [7:0] crc8(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] x;
    x = c ^ b;
    for (int i = 0; i < 8; i++) x = x[7] ? ({x[6:0], 1'b0} ^ 8'h07) : {x[6:0], 1'b0};
    return x;
  endfunction

  wire step     = prim_valid && prim_done;
  wire last_rem = (rem == CW'(1));
  wire bad_req  = (req_kind > K_BPROC) ||
                  (req_kind == K_BWRITE && (req_len == '0 || int'(req_len) > MAX_BLOCK)) ||
                  (req_kind == K_BPROC  && (req_len == '0 || int'(req_len) > MAX_BLOCK - 1));
  wire [7:0] bus_byte = (prim_op == OP_RD) ? prim_rdata : prim_wdata;
  wire bad_cnt  = (prim_rdata == 8'd0) ||
                  (int'(prim_rdata) > ((kind_q == K_BPROC) ? MAX_BLOCK - 1 : MAX_BLOCK));
  wire crc_on   = (st == S_ADDR) || (st == S_CMD) || (st == S_WCNT) || (st == S_WDATA) ||
                  (st == S_ADDR_R) || (st == S_RCNT) || (st == S_RDATA);
  wire st_t after_wr = (kind_q == K_PROC || kind_q == K_BPROC) ? S_RSTART :
                       (pec_q ? S_WPEC : S_STOP);

  assign busy       = (st != S_IDLE);
  assign prim_valid = busy;
  assign tx_pop     = step && (st == S_WDATA);

  always_comb begin
    case (st)
      S_START, S_RSTART:      prim_op = OP_START;
      S_STOP:                 prim_op = OP_STOP;
      S_RCNT, S_RDATA, S_RPEC: prim_op = OP_RD;
      default:                prim_op = OP_WR;
    endcase
    case (st)
      S_ADDR:   prim_wdata = {addr_q, dir_q};
      S_ADDR_R: prim_wdata = {addr_q, 1'b1};
      S_CMD:    prim_wdata = cmd_q;
      S_WCNT:   prim_wdata = 8'(len_q);
      S_WDATA:  prim_wdata = tx_byte;
      S_WPEC:   prim_wdata = crc;
      default:  prim_wdata = 8'h00;
    endcase
    case (st)
      S_RCNT:  prim_ack_out = 1'b1;
      S_RDATA: prim_ack_out = !last_rem || pec_q;
      default: prim_ack_out = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; kind_q <= '0; addr_q <= '0; dir_q <= 1'b0; pec_q <= 1'b0;
      cmd_q <= '0; len_q <= '0; rem <= '0; crc <= '0;
      done <= 1'b0; rx_valid <= 1'b0; rx_data <= '0;
      err_nack <= 1'b0; err_count <= 1'b0; err_pec <= 1'b0;
    end else begin
      done     <= 1'b0;
      rx_valid <= 1'b0;
      if (step && crc_on) crc <= crc8(crc, bus_byte);
      case (st)
        S_IDLE: if (req_valid) begin
          err_nack <= 1'b0; err_pec <= 1'b0;
          if (bad_req) begin
            err_count <= 1'b1; done <= 1'b1;
          end else begin
            err_count <= 1'b0;
            kind_q <= req_kind; addr_q <= req_addr; cmd_q <= req_cmd; len_q <= req_len;
            pec_q  <= req_pec && (req_kind != K_QUICK);
            dir_q  <= (req_kind == K_QUICK) ? req_rw : (req_kind == K_RECV);
            crc    <= '0;
            st     <= S_START;
          end
        end
        S_START:  if (step) st <= S_ADDR;
        S_RSTART: if (step) st <= S_ADDR_R;
        S_ADDR: if (step) begin
          if (!prim_rx_ack) begin err_nack <= 1'b1; st <= S_STOP; end
          else case (kind_q)
            K_QUICK: st <= S_STOP;
            K_RECV:  begin rem <= CW'(1); st <= S_RDATA; end
            K_SEND:  begin rem <= CW'(1); st <= S_WDATA; end
            default: st <= S_CMD;
          endcase
        end
        S_CMD: if (step) begin
          if (!prim_rx_ack) begin err_nack <= 1'b1; st <= S_STOP; end
          else case (kind_q)
            K_WBYTE:          begin rem <= CW'(1); st <= S_WDATA; end
            K_WWORD, K_PROC:  begin rem <= CW'(2); st <= S_WDATA; end
            K_BWRITE, K_BPROC: st <= S_WCNT;
            default:          st <= S_RSTART;
          endcase
        end
        S_WCNT: if (step) begin
          if (!prim_rx_ack) begin err_nack <= 1'b1; st <= S_STOP; end
          else begin rem <= len_q; st <= S_WDATA; end
        end
        S_WDATA: if (step) begin
          if (!prim_rx_ack) begin err_nack <= 1'b1; st <= S_STOP; end
          else begin
            rem <= rem - CW'(1);
            if (last_rem) st <= after_wr;
          end
        end
        S_ADDR_R: if (step) begin
          if (!prim_rx_ack) begin err_nack <= 1'b1; st <= S_STOP; end
          else if (kind_q == K_BREAD || kind_q == K_BPROC) st <= S_RCNT;
          else begin
            rem <= (kind_q == K_RBYTE) ? CW'(1) : CW'(2);
            st  <= S_RDATA;
          end
        end
        S_RCNT: if (step) begin
          if (bad_cnt) begin err_count <= 1'b1; st <= S_STOP; end
          else begin rem <= prim_rdata[CW-1:0]; st <= S_RDATA; end
        end
        S_RDATA: if (step) begin
          rx_valid <= 1'b1;
          rx_data  <= prim_rdata;
          rem      <= rem - CW'(1);
          if (last_rem) st <= pec_q ? S_RPEC : S_STOP;
        end
        S_WPEC: if (step) begin
          if (!prim_rx_ack) err_nack <= 1'b1;
          st <= S_STOP;
        end
        S_RPEC: if (step) begin
          if (prim_rdata != crc) err_pec <= 1'b1;
          st <= S_STOP;
        end
        S_STOP: if (step) begin done <= 1'b1; st <= S_IDLE; end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_prim_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    prim_valid && !prim_done |=> prim_valid && $stable(prim_op));
  assert_addr_after_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    step && prim_op == OP_START |=> prim_valid && prim_op == OP_WR);
  assert_nack_stops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    step && prim_op == OP_WR && !prim_rx_ack |=> prim_valid && prim_op == OP_STOP);
  assert_read_nack_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    step && prim_op == OP_RD && !prim_ack_out |=> prim_valid && prim_op == OP_STOP);
  assert_single_err_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $onehot0({err_nack, err_count, err_pec}));
  assert_idle_on_done_R13: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

// File: tb/smbus_seq_tb.sv
module smbus_seq_tb;
  localparam int CW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_rw = 1'b0, req_pec = 1'b0;
  logic [3:0] req_kind = '0;
  logic [6:0] req_addr = '0;
  logic [7:0] req_cmd = '0;
  logic [CW-1:0] req_len = '0;
  logic [7:0] tx_byte;
  logic tx_pop, rx_valid, busy, done, err_nack, err_count, err_pec;
  logic [7:0] rx_data, prim_wdata;
  logic prim_valid, prim_ack_out;
  logic [1:0] prim_op;
  logic prim_done = 1'b0, prim_rx_ack = 1'b1;
  logic [7:0] prim_rdata = '0;

  int checks = 0, fails = 0;
  int pop_cnt = 0, base = 0;

  always #10 clk = ~clk;

  smbus_seq u_dut (.*);

  function automatic logic [7:0] pay(int i);  return 8'(i * 29 + 60); endfunction
  function automatic logic [7:0] resp(int i); return 8'(i * 53 + 7);  endfunction

  function automatic logic [7:0] crc_ref(logic [7:0] c, logic [7:0] b);
    logic [15:0] w;
    w = {c ^ b, 8'h00};
    for (int i = 15; i >= 8; i--) if (w[i]) w = w ^ (16'h0107 << (i - 8));
    return w[7:0];
  endfunction

  always @(posedge clk) if (tx_pop) pop_cnt <= pop_cnt + 1;
  assign tx_byte = pay(pop_cnt - base);

  int e_op[160];
  logic [7:0] e_byte[160];
  logic e_ack[160];
  string e_tag[160];
  int n, cnt_idx, pec_idx, n_wr, n_rd;
  logic [7:0] bcrc;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(int op, logic [7:0] b, logic a, string t, bit upd);
    e_op[n] = op; e_byte[n] = b; e_ack[n] = a; e_tag[n] = t;
    if (upd) bcrc = crc_ref(bcrc, b);
    n++;
  endtask

  function automatic string ktag(int k);
    case (k)
      0: return "R2";
      1, 2, 3: return "R14";
      4: return "R3";
      5, 6, 7: return "R4";
      8: return "R7";
      9: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic build(int k, int rw, int len, int pec, int rc, logic [6:0] a, logic [7:0] c);
    string kt;
    logic dir;
    kt = ktag(k);
    n = 0; bcrc = '0; cnt_idx = -1; pec_idx = -1;
    dir = (k == 0) ? 1'(rw) : (k == 2);
    push(0, 8'h00, 1'b0, "R1", 0);
    push(2, {a, dir}, 1'b0, "R1", 1);
    n_wr = 0; n_rd = 0;
    if (k != 0) begin
      if (k >= 3) push(2, c, 1'b0, kt, 1);
      if (k == 8 || k == 10) push(2, 8'(len), 1'b0, kt, 1);
      n_wr = (k == 1 || k == 3) ? 1 : (k == 5 || k == 7) ? 2 : (k == 8 || k == 10) ? len : 0;
      for (int i = 0; i < n_wr; i++) push(2, pay(i), 1'b0, kt, 1);
      if (k == 4 || k == 6 || k == 7 || k == 9 || k == 10) begin
        push(0, 8'h00, 1'b0, "R3", 0);
        push(2, {a, 1'b1}, 1'b0, "R1", 1);
      end
      n_rd = (k == 2 || k == 4) ? 1 : (k == 6 || k == 7) ? 2 : (k == 9 || k == 10) ? rc : 0;
      if (k == 9 || k == 10) begin cnt_idx = n; push(3, 8'(rc), 1'b1, kt, 1); end
      for (int i = 0; i < n_rd; i++)
        push(3, resp(i), (i != n_rd - 1) || pec != 0, (i == n_rd - 1) ? "R5" : kt, 1);
      if (pec != 0) begin
        pec_idx = n;
        push((n_rd > 0) ? 3 : 2, bcrc, 1'b0, "R9", 0);
      end
    end
    push(1, 8'h00, 1'b0, kt, 0);
  endtask

  task automatic run(int k, int rw, int len, int pec, int rc,
                     int nack_at, int bad_cnt, int pec_bad, int poke);
    int idx, rxn, cyc;
    bit fin, jump;
    string kt;
    logic [6:0] a;
    logic [7:0] c;
    a = 7'(7'h21 + k * 9 + len);
    c = 8'(8'hA0 + k + len * 3);
    kt = ktag(k);
    build(k, rw, len, pec, rc, a, c);
    @(negedge clk);
    base = pop_cnt;
    req_kind = 4'(k); req_addr = a; req_cmd = c; req_len = CW'(len);
    req_rw = 1'(rw); req_pec = 1'(pec); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    idx = 0; rxn = 0; cyc = 0; fin = 0;
    while (!fin) begin
      if (rx_valid) begin
        chk(rx_data == resp(rxn), "R5 rx data", rx_data, resp(rxn));
        rxn++;
      end
      if (done) fin = 1;
      else begin
        if (prim_valid) begin
          if (idx >= n) begin
            chk(0, "R1 extra primitive", prim_op, 1);
            fin = 1;
          end else begin
            chk(prim_op == 2'(e_op[idx]), e_tag[idx], prim_op, e_op[idx]);
            if (e_op[idx] == 2) chk(prim_wdata == e_byte[idx], e_tag[idx], prim_wdata, e_byte[idx]);
            if (e_op[idx] == 3) chk(prim_ack_out == e_ack[idx],
                                    (e_tag[idx] == "R9") ? "R9" : "R5", prim_ack_out, e_ack[idx]);
            jump = 0;
            prim_rx_ack = 1'b1;
            prim_rdata = e_byte[idx];
            if (e_op[idx] == 2 && idx == nack_at) begin prim_rx_ack = 1'b0; jump = 1; end
            if (idx == cnt_idx && bad_cnt >= 0) begin prim_rdata = 8'(bad_cnt); jump = 1; end
            if (idx == pec_idx && pec_bad != 0) prim_rdata = ~e_byte[idx];
            prim_done = 1'b1;
            idx = jump ? n - 1 : idx + 1;
          end
        end
        if (poke != 0 && idx == 3) begin req_valid = 1'b1; req_kind = 4'd1; end
        else req_valid = 1'b0;
        @(negedge clk);
        prim_done = 1'b0;
        prim_rx_ack = 1'b1;
        cyc++;
        if (cyc > 600) begin chk(0, "R1 hung transaction", cyc, 0); fin = 1; end
      end
    end
    req_valid = 1'b0;
    chk(idx == n, (poke != 0) ? "R13 trace length" : kt, idx, n);
    chk(err_nack == (nack_at >= 0), "R10 err_nack", err_nack, nack_at >= 0);
    chk(err_count == (bad_cnt >= 0), "R11 err_count", err_count, bad_cnt >= 0);
    chk(err_pec == (pec_bad != 0), "R12 err_pec", err_pec, pec_bad != 0);
    if (nack_at < 0 && bad_cnt < 0) begin
      chk(rxn == n_rd, "R5 rx count", rxn, n_rd);
      chk(pop_cnt - base == n_wr, "R7 pop count", pop_cnt - base, n_wr);
    end
  endtask

  task automatic run_reject(int k, int len);
    int seen;
    seen = 0;
    @(negedge clk);
    req_kind = 4'(k); req_len = CW'(len); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (prim_valid) seen++;
    chk(done && err_count, "R11 rejected request", {done, err_count}, 3);
    repeat (3) begin
      @(negedge clk);
      if (prim_valid) seen++;
    end
    chk(seen == 0, "R11 no bus activity", seen, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !prim_valid && !done, "R1 reset state", {busy, prim_valid, done}, 0);
    chk(!err_nack && !err_count && !err_pec, "R11 reset flags", {err_nack, err_count, err_pec}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !prim_valid, "R1 idle after reset", {busy, prim_valid}, 0);

    for (int k = 0; k <= 7; k++)
      for (int p = 0; p < 2; p++)
        for (int rw = 0; rw < 2; rw++)
          run(k, rw, 1, p, 1, -1, -1, 0, 0);
    for (int p = 0; p < 2; p++) begin
      for (int L = 1; L <= 32; L++) run(8, 0, L, p, 1, -1, -1, 0, 0);
      for (int L = 1; L <= 32; L++) run(9, 0, 1, p, L, -1, -1, 0, 0);
      for (int L = 1; L <= 31; L++) run(10, 0, L, p, 32 - L, -1, -1, 0, 0);
    end

    begin
      int ks[3];
      ks = '{5, 7, 10};
      for (int j = 0; j < 3; j++) begin
        int wpos[40];
        int nw;
        build(ks[j], 0, 3, 1, 2, 7'h00, 8'h00);
        nw = 0;
        for (int i = 0; i < n; i++) if (e_op[i] == 2) begin wpos[nw] = i; nw++; end
        for (int i = 0; i < nw; i++) run(ks[j], 0, 3, 1, 2, wpos[i], -1, 0, 0);
      end
    end

    run(9, 0, 1, 0, 4, -1, 0, 0, 0);
    run(9, 0, 1, 1, 4, -1, 33, 0, 0);
    run(9, 0, 1, 0, 4, -1, 255, 0, 0);
    run(10, 0, 2, 0, 4, -1, 0, 0, 0);
    run(10, 0, 2, 1, 4, -1, 32, 0, 0);

    run(2, 0, 1, 1, 1, -1, -1, 1, 0);
    run(4, 0, 1, 1, 1, -1, -1, 1, 0);
    run(6, 0, 1, 1, 1, -1, -1, 1, 0);
    run(7, 0, 1, 1, 1, -1, -1, 1, 0);
    run(9, 0, 1, 1, 5, -1, -1, 1, 0);
    run(10, 0, 3, 1, 5, -1, -1, 1, 0);

    run_reject(8, 0);
    run_reject(8, 33);
    run_reject(10, 0);
    run_reject(10, 32);
    run_reject(11, 1);
    run_reject(15, 1);

    run(7, 0, 1, 1, 1, -1, -1, 0, 1);
    run(10, 0, 4, 0, 3, -1, -1, 0, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule